// File: doc/BRIEF.md
# Lockable Range Write-Protect Controller

This block guards a 13-bit byte-addressed serial memory of 64 Kbit. The memory is split into sixteen 512-byte blocks, and the block index is address bits [12:9]. It sits behind a serial-bus slave front end, which hands it every received byte with that byte's index in the current transaction, plus start and stop events. Byte index 0 is the first address byte after the control byte.

An ordinary write puts the upper address bits in byte 0 and the lower eight in byte 1. Every later byte is a data byte at an address that advances by one per byte. For each data byte the block issues a memory write one cycle later, unless the address falls inside the protected window. A protected byte is dropped silently, and the bus transaction goes on as usual.

A write whose byte 0 has bit 7 set is a configuration command instead. It can program the window once, or select a readback of the window settings. A readback returns the stored start block and then the stored block count, one byte per read request.

Top module: `wp_range_ctrl`

## Requirements
- R1: A data byte at address A is protected when blk = A[12:9] satisfies start <= blk < start + count, with the sum taken without wrapping, so a window that runs past block 15 is clipped there.
- R2: With a block count of 0, no address is protected, whatever the start block.
- R3: From reset until the first commit, the stored start block is 15 and the block count is 0.
- R4: Only the first commit takes effect. Later configuration commands still proceed on the bus, but they leave the stored values unchanged.
- R5: In a configuration command, byte 0 must have bit 7 set and carries the start block in bits [4:1]. Bits 6, 5 and 0 of byte 0 have no effect.
- R6: Byte 2 of a configuration command programs the window only when bit 7 = 1 and bit 6 = 0. Its bits [3:0] give the count, and bits [5:4] have no effect. If byte 2 has bit 7 = 0, or a fourth byte follows, nothing is committed.
- R7: A commit happens only on a stop that ends a complete programming command. A start or a stop arriving earlier discards the command.
- R8: When byte 2 of a configuration command has bits 7 and 6 both set, each rd_req_i is answered one cycle later with rd_vld_o high. The first answer is {4'b1111, start} and every later answer is {4'b1111, count}.
- R9: A data byte in an ordinary write gives mem_we_o = 1 one cycle after its strobe, with mem_addr_o and mem_data_o carrying that byte, provided its address is unprotected. For a protected address mem_we_o stays 0 and nothing else changes.
- R10: Data bytes from index 2 onward go to consecutive addresses, wrapping modulo 8192. In a write that crosses the window edge, each byte is kept or dropped on its own address.
- R11: Byte 1 of a configuration command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_idx_i | input | 8 | Index of the byte in the transaction |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for the next readback byte |
| mem_we_o | output | 1 | Byte write to the array |
| mem_addr_o | output | 13 | Write address |
| mem_data_o | output | 8 | Write data |
| rdbk_o | output | 1 | Readback mode is selected in this transaction |
| rd_vld_o | output | 1 | Readback byte valid |
| rd_data_o | output | 8 | Readback byte |

## Verification
The bench aims at the edges of the window. It runs writes that cross from an unprotected block into a protected one and back out again. A design with an off-by-one in its comparison would keep or drop the wrong byte at that edge. It also programs a window of start 12 and count 15: a design whose limit sum wraps would leave block 15 writable.

Other runs cover configuration commands that are incomplete, malformed, too long or aborted. These must leave the defaults intact, and a design that commits too early or without a stop would show the new values on readback. A second programming attempt with different values catches a lock that is missing or not sticky. Don't-care bits are randomized throughout, so a decoder that reads the wrong bit positions returns the wrong readback nibbles.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_NORM,
    TX_CFG,
    TX_CFG_DONE,
    TX_CFG_BAD,
    TX_RDBK
  } tx_state_e;
endpackage

// File: rtl/wrp_cmd_decode.sv
module wrp_cmd_decode import wrp_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [7:0]        byte_i,
  output logic              wr_evt_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              prog_ready_o,
  output logic [BLK_W-1:0]  prog_start_o,
  output logic [BLK_W-1:0]  prog_cnt_o,
  output logic              rdbk_o
);
  localparam int HI_W = ADDR_W - 8;

  tx_state_e         state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BLK_W-1:0]  start_q, cnt_q;
  logic              idx0, idx1, idx2, idx_data;

  assign idx0     = byte_idx_i == IDX_W'(0);
  assign idx1     = byte_idx_i == IDX_W'(1);
  assign idx2     = byte_idx_i == IDX_W'(2);
  assign idx_data = byte_idx_i >= IDX_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      ptr_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (start_i || stop_i) begin
      state_q <= TX_IDLE;
    end else if (byte_vld_i) begin
      if (idx0) begin
        if (byte_i[7]) begin
          state_q <= TX_CFG;
          start_q <= byte_i[BLK_W:1];
        end else begin
          state_q <= TX_NORM;
          ptr_q[ADDR_W-1:8] <= byte_i[HI_W-1:0];
        end
      end else if (idx1) begin
        if (state_q == TX_NORM) ptr_q[7:0] <= byte_i;
      end else begin
        unique case (state_q)
          TX_NORM: ptr_q <= ptr_q + ADDR_W'(1);
          TX_CFG: begin
            if (idx2 && byte_i[7] && !byte_i[6]) begin
              state_q <= TX_CFG_DONE;
              cnt_q   <= byte_i[BLK_W-1:0];
            end else if (idx2 && byte_i[7]) begin
              state_q <= TX_RDBK;
            end else begin
              state_q <= TX_CFG_BAD;
            end
          end
          TX_CFG_DONE: state_q <= TX_CFG_BAD;  // overlong command
          default: ;
        endcase
      end
    end
  end

  assign wr_evt_o     = byte_vld_i && idx_data && (state_q == TX_NORM);
  assign wr_addr_o    = ptr_q;
  assign wr_data_o    = byte_i;
  assign prog_ready_o = state_q == TX_CFG_DONE;
  assign prog_start_o = start_q;
  assign prog_cnt_o   = cnt_q;
  assign rdbk_o       = state_q == TX_RDBK;
endmodule

// File: rtl/wrp_cfg_store.sv
module wrp_cfg_store #(
  parameter int BLK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [BLK_W-1:0] start_i,
  input  logic [BLK_W-1:0] cnt_i,
  output logic [BLK_W-1:0] start_o,
  output logic [BLK_W-1:0] cnt_o,
  output logic             locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o  <= '1;
      cnt_o    <= '0;
      locked_o <= 1'b0;
    end else if (commit_i && !locked_o) begin
      start_o  <= start_i;
      cnt_o    <= cnt_i;
      locked_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wrp_range_check.sv
module wrp_range_check #(
  parameter int BLK_W = 4
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] start_i,
  input  logic [BLK_W-1:0] cnt_i,
  output logic             prot_o
);
  logic [BLK_W:0] lim;
  // one extra bit: limit past the top block clips instead of wrapping
  assign lim    = {1'b0, start_i} + {1'b0, cnt_i};
  assign prot_o = (cnt_i != '0) && (blk_i >= start_i) && ({1'b0, blk_i} < lim);
endmodule

// File: rtl/wrp_readback.sv
module wrp_readback #(
  parameter int BLK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rdbk_i,
  input  logic             rd_req_i,
  input  logic [BLK_W-1:0] start_i,
  input  logic [BLK_W-1:0] cnt_i,
  output logic             rd_vld_o,
  output logic [7:0]       rd_data_o
);
  logic             second_q;
  logic [BLK_W-1:0] val;
  logic [7:0]       word;

  assign val = second_q ? cnt_i : start_i;

  generate
    if (BLK_W < 8) begin : g_pad
      assign word = {{(8 - BLK_W){1'b1}}, val};
    end else begin : g_full
      assign word = val[7:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q  <= 1'b0;
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= rdbk_i && rd_req_i;
      if (!rdbk_i) begin
        second_q <= 1'b0;
      end else if (rd_req_i) begin
        rd_data_o <= word;
        second_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_range_ctrl.sv
module wp_range_ctrl #(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [7:0]        byte_i,
  input  logic              rd_req_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              rdbk_o,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o
);
  logic              wr_evt, prog_ready, prot, rdbk;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [BLK_W-1:0]  prog_start, prog_cnt;
  logic [BLK_W-1:0]  cfg_start, cfg_cnt;
  logic              cfg_locked;

  wrp_cmd_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_dec (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_idx_i, .byte_i,
    .wr_evt_o(wr_evt), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .prog_ready_o(prog_ready), .prog_start_o(prog_start), .prog_cnt_o(prog_cnt),
    .rdbk_o(rdbk)
  );

  wrp_cfg_store #(.BLK_W(BLK_W)) u_cfg (
    .clk_i, .rst_ni,
    .commit_i(stop_i && prog_ready),
    .start_i(prog_start), .cnt_i(prog_cnt),
    .start_o(cfg_start), .cnt_o(cfg_cnt), .locked_o(cfg_locked)
  );

  wrp_range_check #(.BLK_W(BLK_W)) u_rng (
    .blk_i(wr_addr[ADDR_W-1 -: BLK_W]),
    .start_i(cfg_start), .cnt_i(cfg_cnt), .prot_o(prot)
  );

  wrp_readback #(.BLK_W(BLK_W)) u_rb (
    .clk_i, .rst_ni, .rdbk_i(rdbk), .rd_req_i,
    .start_i(cfg_start), .cnt_i(cfg_cnt),
    .rd_vld_o, .rd_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= wr_evt && !prot;
      if (wr_evt && !prot) begin
        mem_addr_o <= wr_addr;
        mem_data_o <= wr_data;
      end
    end
  end

  assign rdbk_o = rdbk;
endmodule

// File: rtl/wp_range_ctrl_chk.sv
module wp_range_ctrl_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             mem_we_o,
  input logic [BLK_W-1:0] mem_blk,
  input logic             rd_vld_o,
  input logic [7:0]       rd_data_o,
  input logic [BLK_W-1:0] cfg_start,
  input logic [BLK_W-1:0] cfg_cnt,
  input logic             cfg_locked
);
  logic [BLK_W:0] blk_p1, top;
  assign blk_p1 = {1'b0, mem_blk} + 1'b1;
  assign top    = {1'b0, cfg_start} + {1'b0, cfg_cnt};

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked |=> cfg_locked); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_locked |=> ($stable(cfg_start) && $stable(cfg_cnt))); // R4
  AST_DEFAULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_locked |-> (cfg_start == '1 && cfg_cnt == '0)); // R3
  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(cfg_start) && $stable(cfg_cnt)) |-> $past(stop_i)); // R7
  AST_NO_PROT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (cfg_cnt == '0 || mem_blk < cfg_start || blk_p1 > top)); // R9
  AST_RD_UPPER_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (&rd_data_o[7:BLK_W])); // R8
endmodule

bind wp_range_ctrl wp_range_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i),
  .mem_we_o(mem_we_o), .mem_blk(mem_addr_o[ADDR_W-1 -: BLK_W]),
  .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o),
  .cfg_start(cfg_start), .cfg_cnt(cfg_cnt), .cfg_locked(cfg_locked)
);

// File: tb/wp_range_ctrl_tb_top.sv
module wp_range_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0]  byte_idx_i = '0, byte_i = '0;
  logic        mem_we_o, rdbk_o, rd_vld_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_data_o, rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_s = 15, exp_c = 0;
  bit exp_lock = 0;

  always #4 clk = ~clk;

  wp_range_ctrl dut_i (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_idx_i, .byte_i,
    .rd_req_i, .mem_we_o, .mem_addr_o, .mem_data_o, .rdbk_o, .rd_vld_o, .rd_data_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_prot(input int a, input int s, input int c);
    int blk = (a >> 9) & 15;
    return (c != 0) && (blk >= s) && (blk < s + c);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    exp_s = 15; exp_c = 0; exp_lock = 0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic put_byte(input int idx, input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_idx_i = 8'(idx); byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic normal_write(input logic [12:0] addr, input int len, input string req);
    pulse_start();
    put_byte(0, {3'b000, addr[12:8]});
    put_byte(1, addr[7:0]);
    for (int k = 0; k < len; k++) begin
      logic [7:0]  d = 8'($urandom);
      logic [12:0] a = addr + 13'(k);
      put_byte(2 + k, d);
      if (exp_prot(a, exp_s, exp_c))
        chk(mem_we_o == 1'b0, {req, " dropped"}, mem_we_o, 0);
      else
        chk(mem_we_o && mem_addr_o == a && mem_data_o == d, {req, " written"},
            {mem_we_o, mem_addr_o, mem_data_o}, {1'b1, a, d});
    end
    pulse_stop();
  endtask

  // kind: 0 = stop, 1 = abort with start, 2 = extra byte then stop
  task automatic cfg_cmd(input logic [7:0] b0, input logic [7:0] b2, input int kind);
    pulse_start();
    put_byte(0, b0);
    put_byte(1, 8'($urandom));
    put_byte(2, b2);
    if (kind == 2) put_byte(3, 8'($urandom));
    if (kind == 1) pulse_start();
    pulse_stop();
    if (kind == 0 && b0[7] && b2[7] && !b2[6] && !exp_lock) begin
      exp_s = b0[4:1]; exp_c = b2[3:0]; exp_lock = 1;
    end
  endtask

  task automatic readback(input string req);
    logic [7:0] r0, r1, r2;
    r0 = 8'h80 | (8'($urandom) & 8'h7F);
    r2 = 8'hC0 | (8'($urandom) & 8'h3F);
    pulse_start();
    put_byte(0, r0);
    put_byte(1, 8'($urandom));
    put_byte(2, r2);
    chk(rdbk_o == 1'b1, {req, " R8 mode"}, rdbk_o, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_req_i = 1'b1;
      @(negedge clk); rd_req_i = 1'b0;
      r1 = (i == 0) ? {4'hF, 4'(exp_s)} : {4'hF, 4'(exp_c)};
      chk(rd_vld_o && rd_data_o == r1, {req, " R8 byte"}, rd_data_o, r1);
    end
    pulse_stop();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    chk(mem_we_o == 0 && rd_vld_o == 0 && rdbk_o == 0, "R3 reset outputs",
        {mem_we_o, rd_vld_o, rdbk_o}, 0);
    readback("R3 defaults");

    // R2: default count 0, everything writable
    for (int i = 0; i < 20; i++)
      normal_write(13'($urandom), 1 + int'($urandom % 4), "R2 unprotected");

    // R7: abort by start; R6: bad third byte, overlong command
    cfg_cmd(8'h8A, 8'h83, 1);
    readback("R7 aborted");
    cfg_cmd(8'h8A, 8'h03, 0);
    readback("R6 bit7 clear");
    cfg_cmd(8'h8A, 8'h83, 2);
    readback("R6 overlong");
    pulse_stop();
    readback("R7 lone stop");

    // R5 R6 R11: start 5 with bits 6,5,0 set; count 3 with bits 5:4 set
    cfg_cmd(8'hEB, 8'hB3, 0);
    readback("R5 R11 programmed");
    chk(exp_s == 5 && exp_c == 3, "R5 model", exp_s * 16 + exp_c, 16'h53);

    // R10: crossings into and out of the window
    normal_write(13'h09FE, 4, "R10 enter window");
    normal_write(13'h0FFE, 4, "R10 leave window");
    normal_write(13'h1FFF, 2, "R10 wrap");

    // R1 R9: random writes
    for (int i = 0; i < 200; i++)
      normal_write(13'($urandom), 1 + int'($urandom % 5), "R1 R9 random");

    // R4: second programming ignored
    cfg_cmd(8'h80, 8'h8F, 0);
    readback("R4 relock");
    normal_write(13'h0000, 2, "R4 block0 still writable");

    // R1 clip: start 12 count 15
    do_reset();
    cfg_cmd(8'h98, 8'h8F, 0);
    readback("R1 clip cfg");
    normal_write(13'h17FE, 4, "R1 clip edge");
    normal_write(13'h1FFE, 2, "R1 top block");
    for (int i = 0; i < 50; i++)
      normal_write(13'($urandom), 1 + int'($urandom % 3), "R1 clip random");

    // R2: nonzero start, zero count
    do_reset();
    cfg_cmd(8'h86, 8'h80, 0);
    readback("R2 zero count cfg");
    for (int i = 0; i < 20; i++)
      normal_write(13'($urandom), 2, "R2 zero count");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule